// File: doc/BRIEF.md
# Memory-Stall Cycle Activity Counters

This block counts, for one hardware thread, the cycles in which load misses are waiting on the memory hierarchy. Each cycle it looks at the outstanding miss entries of the first-level data cache and of the second-level cache. Every entry carries a valid bit and a tag that says whether a demand load or a hardware prefetcher raised it. It also looks at a flag that says whether any micro-op was dispatched in the cycle, and at a flag that says whether the thread is unhalted.

Five saturating counters are kept:
- cycles with a demand L1 miss pending;
- cycles with a demand L2 miss pending;
- the same two conditions restricted to cycles in which nothing was dispatched;
- an unhalted-cycle reference count.

Prefetch entries never qualify. The L2 condition is only accepted together with the L1 condition. As a result, a profiler can compute the L2-bound fraction (L1 stalls minus L2 stalls, divided by clocks) and never get a negative value.

Software works through a small register port. It reads any counter through a combinational read port, sets per-counter enables, and clears counters or sticky flags with a write mask.

Top module: `mem_stall_counters`

## Requirements
- R1: Counter 0 (read address 0) adds one in each cycle where the thread is active and at least one L1 miss entry is valid with its prefetch tag low.
- R2: Counter 1 (address 1) adds one in each cycle where the thread is active and a valid demand L2 miss entry exists, provided the R1 condition also holds.
- R3: Counter 2 (address 2) adds one only in cycles meeting the R1 condition with `dispatched` low.
- R4: Counter 3 (address 3) adds one only in cycles meeting the R2 condition with `dispatched` low.
- R5: Entries whose prefetch tag is high never satisfy any pending condition.
- R6: A cycle with a valid demand L2 entry and no valid demand L1 entry does not advance counters 1 or 3, and it sets the sticky input-consistency bit (status bit 5).
- R7: When `active` is low, no counter advances; counter 4 (address 4) adds one in each active cycle.
- R8: Enables sit at address 5, with bit i enabling counter i. They reset to all ones and are written with `wr_en`. A counter whose enable is low holds its value. A new enable value applies from the cycle after the write.
- R9: Writing address 7 with bit i set (i in 0..4) clears counter i and its overflow bit at that clock edge. Bit 5 clears the consistency bit. A clear wins over a same-cycle increment or flag set. Address 7 reads as zero.
- R10: A counter at all ones that would increment stays at all ones and sets its sticky overflow bit (status address 6, bit i for counter i).
- R11: `rd_data` is a combinational view of the registered state at `rd_addr`, so it shows the values as of the last clock edge. After reset all counters and status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | Thread unhalted in this cycle |
| dispatched | input | 1 | At least one micro-op dispatched this cycle |
| l1_valid | input | NE | Valid bits of the L1 miss entries |
| l1_is_pf | input | NE | Prefetch tag of each L1 miss entry |
| l2_valid | input | NE | Valid bits of the L2 miss entries |
| l2_is_pf | input | NE | Prefetch tag of each L2 miss entry |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CW | Register read data |

## Verification
Every counter, flag and enable changes at the first rising edge after the cycle in which its stimulus or write is presented. Because the read port is combinational, the new value is visible on `rd_data` straight after that edge. The bench drives inputs on the falling edge and lets the rising edge capture them. It then updates its own model and compares `rd_data` on the next falling edge, so each comparison is due exactly one edge after its stimulus. The bench runs with a narrow counter width so that the saturation and overflow cases are reached within the run.

// File: rtl/mem_stall_counters.sv
module mem_stall_counters #(
  parameter int CW = 48,
  parameter int NE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          dispatched,
  input  logic [NE-1:0] l1_valid,
  input  logic [NE-1:0] l1_is_pf,
  input  logic [NE-1:0] l2_valid,
  input  logic [NE-1:0] l2_is_pf,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [CW-1:0] rd_data
);
  localparam int NC = 5;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic [NC-1:0][CW-1:0] cnt;
  logic [NC-1:0]         en;
  logic [NC-1:0]         ovf;
  logic                  err;

  wire l1p = |(l1_valid & ~l1_is_pf);
  wire l2p = |(l2_valid & ~l2_is_pf);

  wire [NC-1:0] q;
  assign q[0] = active & l1p;
  assign q[1] = active & l1p & l2p;
  assign q[2] = q[0] & ~dispatched;
  assign q[3] = q[1] & ~dispatched;
  assign q[4] = active;

  wire [5:0] clr = (wr_en && wr_addr == 3'd7) ? wr_data[5:0] : 6'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= '0;
      en  <= '1;
      err <= 1'b0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (clr[i]) begin
          cnt[i] <= '0;
          ovf[i] <= 1'b0;
        end else if (en[i] && q[i]) begin
          if (cnt[i] == MAXV) ovf[i] <= 1'b1;
          else                cnt[i] <= cnt[i] + 1'b1;
        end
      end
      if (wr_en && wr_addr == 3'd5) en <= wr_data[NC-1:0];
      if (clr[5])             err <= 1'b0;
      else if (l2p && !l1p)   err <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: rd_data = cnt[rd_addr];
      3'd5:    rd_data = {{(CW-NC){1'b0}}, en};
      3'd6:    rd_data = {{(CW-NC-1){1'b0}}, err, ovf};
      default: rd_data = '0;
    endcase
  end

  for (genvar g = 0; g < NC; g++) begin : g_chk
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr[g] |=> (cnt[g] == '0 && !ovf[g]));
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[g] && en[g] && q[g] && cnt[g] == MAXV) |=> (cnt[g] == MAXV && ovf[g]));
    a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[g] && !en[g]) |=> $stable(cnt[g]));
    a_r7_halted_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clr[g]) |=> $stable(cnt[g]));
  end

  a_r3_dispatch_no_stall_l1: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatched && !clr[2]) |=> $stable(cnt[2]));
  a_r4_dispatch_no_stall_l2: assert property (@(posedge clk) disable iff (!rst_n)
    (dispatched && !clr[3]) |=> $stable(cnt[3]));
  a_r5_prefetch_only_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(l1_valid & ~l1_is_pf)) && !clr[0] && !clr[1]) |=> ($stable(cnt[0]) && $stable(cnt[1])));
  a_r6_consistency_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (l2p && !l1p && !clr[5]) |=> err);
  a_r6_l2_needs_l1: assert property (@(posedge clk) disable iff (!rst_n)
    (!l1p && !clr[1] && !clr[3]) |=> ($stable(cnt[1]) && $stable(cnt[3])));
endmodule

// File: tb/test_mem_stall_counters.sv
module test_mem_stall_counters;
  localparam int CW = 10;
  localparam int NE = 4;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, active = 1'b0, dispatched = 1'b0;
  logic [NE-1:0] l1_valid = '0, l1_is_pf = '0, l2_valid = '0, l2_is_pf = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] rd_data;

  int checks = 0, failures = 0, cyc = 0;

  logic [CW-1:0] m_cnt [5];
  logic [4:0] m_en, m_ovf;
  logic m_err;

  always #4 clk = ~clk;

  mem_stall_counters #(.CW(CW), .NE(NE)) i_mem_stall_counters (
    .clk(clk), .rst_n(rst_n), .active(active), .dispatched(dispatched),
    .l1_valid(l1_valid), .l1_is_pf(l1_is_pf), .l2_valid(l2_valid), .l2_is_pf(l2_is_pf),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic demand(input logic [NE-1:0] v, input logic [NE-1:0] pf);
    return |(v & ~pf);
  endfunction

  function automatic logic [4:0] qualify();
    logic a, b;
    a = active & demand(l1_valid, l1_is_pf);
    b = a & demand(l2_valid, l2_is_pf);
    return {active, b & ~dispatched, a & ~dispatched, b, a};
  endfunction

  function automatic logic [CW-1:0] mread(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd2, 3'd3, 3'd4: return m_cnt[a];
      3'd5: return {{(CW-5){1'b0}}, m_en};
      3'd6: return {{(CW-6){1'b0}}, m_err, m_ovf};
      default: return '0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] a);
    case (a)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R7"; 3'd5: return "R8"; 3'd6: return "R10"; default: return "R9";
    endcase
  endfunction

  task automatic check(input string r, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%0h expected=%0h", r, rd_addr, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_cnt[i] = '0;
    m_en = '1; m_ovf = '0; m_err = 1'b0;
  endtask

  task automatic tick();
    logic [4:0] q;
    logic [5:0] c;
    q = qualify();
    c = (wr_en && wr_addr == 3'd7) ? wr_data[5:0] : 6'd0;
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      if (c[i]) begin m_cnt[i] = '0; m_ovf[i] = 1'b0; end
      else if (m_en[i] && q[i]) begin
        if (m_cnt[i] == MAXV) m_ovf[i] = 1'b1;
        else m_cnt[i] = m_cnt[i] + 1'b1;
      end
    end
    if (wr_en && wr_addr == 3'd5) m_en = wr_data[4:0];
    if (c[5]) m_err = 1'b0;
    else if (demand(l2_valid, l2_is_pf) && !demand(l1_valid, l1_is_pf)) m_err = 1'b1;
    @(negedge clk);
    check(tag(rd_addr), rd_data, mread(rd_addr));
    wr_en = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] held;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      check("R11", rd_data, (a == 5) ? {{(CW-5){1'b0}}, 5'h1f} : '0);
    end

    // R1 R3: demand L1 only, no dispatch
    active = 1; dispatched = 0; l1_valid = 4'b0010; rd_addr = 3'd2;
    repeat (5) tick();
    rd_addr = 3'd0; tick();
    check("R1", rd_data, 10'd6);
    rd_addr = 3'd1; tick();
    check("R2", rd_data, 10'd0);

    // R5: prefetch-only entries
    l1_valid = 4'b1111; l1_is_pf = 4'b1111; l2_valid = 4'b0001; l2_is_pf = 4'b0001;
    rd_addr = 3'd0; #1; held = rd_data;
    repeat (20) tick();
    check("R5", rd_data, held);

    // R6: L2 demand without L1 demand
    l1_valid = 0; l1_is_pf = 0; l2_valid = 4'b0100; l2_is_pf = 0; rd_addr = 3'd1;
    #1; held = rd_data;
    repeat (4) tick();
    check("R6", rd_data, held);
    rd_addr = 3'd6; #1;
    check("R6", rd_data[5], 1'b1);
    reg_write(3'd7, 10'h020);
    check("R9", rd_data[5], 1'b0);

    // R7: halted thread
    active = 0; l1_valid = 4'b1; l2_valid = 4'b1; rd_addr = 3'd4; #1; held = rd_data;
    repeat (6) tick();
    check("R7", rd_data, held);
    active = 1;

    // R8: disable stall-L1 counter
    reg_write(3'd5, 10'h01b);
    rd_addr = 3'd2; #1; held = rd_data;
    repeat (5) tick();
    check("R8", rd_data, held);
    reg_write(3'd5, 10'h01f);

    // R9: clear wins over increment
    rd_addr = 3'd0;
    reg_write(3'd7, 10'h001);
    check("R9", rd_data, 10'd0);

    // R10: saturation of all counters
    reg_write(3'd7, 10'h03f);
    l1_valid = 4'b1000; l2_valid = 4'b1000; l1_is_pf = 0; l2_is_pf = 0; dispatched = 0;
    rd_addr = 3'd3;
    repeat (1030) tick();
    check("R10", rd_data, MAXV);
    rd_addr = 3'd6; tick();
    check("R10", rd_data[4:0], 5'h1f);
    reg_write(3'd7, 10'h03f);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      active     = ($urandom_range(9) != 0);
      dispatched = $urandom_range(1);
      l1_valid = NE'($urandom); l1_is_pf = NE'($urandom);
      l2_valid = ($urandom_range(3) == 0) ? NE'($urandom) : (l1_valid & NE'($urandom));
      l2_is_pf = NE'($urandom);
      rd_addr = 3'($urandom);
      if ($urandom_range(199) == 0) begin
        wr_en = 1; wr_addr = 3'd5; wr_data = CW'($urandom_range(31) | 1);
      end else if ($urandom_range(299) == 0) begin
        wr_en = 1; wr_addr = 3'd7; wr_data = CW'($urandom_range(63));
      end else if ($urandom_range(99) == 0) begin
        wr_en = 1; wr_addr = 3'($urandom_range(4)); wr_data = CW'($urandom);
      end
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule